// File: doc/BRIEF.md
# Sigma-Delta Fractional-N Feedback Divider

This block divides a fast stream of input clock-enable strobes by a programmable ratio N = INT + FRAC/MOD. The ratio holds on average over many output cycles. Each output period lasts a whole number of input strobes. That number is INT plus a signed offset from a third-order noise-shaping modulator. The modulator is built as three cascaded first-order accumulators, each of modulus MOD. Their carries are combined so that the offset stays between -3 and +4, and the quantisation error is pushed to high frequencies.

The per-period integer divide is counted out by a dual-modulus prescaler model. A main counter and a swallow counter steer a prescaler that divides by P or by P+1, where P is 4 or 8 as selected. The modulator steps once per output pulse, and the new divide value is loaded at the terminal count.

The input strobe `in_en` is a plain qualifier with no back-pressure: every cycle in which it is high counts as one input edge. `div_pulse` is a one-cycle strobe that nothing can stall. INT, FRAC, MOD and the prescaler select are static configuration, changed only while reset is asserted. FRAC must be below MOD, and MOD must be at least 1. A sticky error flag reports divide values that the selected prescaler cannot realise.

Top module: `frac_n_divider`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `div_pulse` and `div_err` and sets `div_value` to INT.
- R2: The number of cycles with `in_en` high between successive `div_pulse` strobes equals the `div_value` in force for that period. The strobe rises one clock after the edge that takes the last counted `in_en`. Cycles with `in_en` low are ignored and do not advance the count.
- R3: Every `div_value` equals INT plus an offset in the range -3 to +4.
- R4: The first period after reset uses an offset of 0. At every `div_pulse`, `div_value` takes INT plus the next modulator output y. The modulator is defined as follows.
  - Three accumulators a1, a2 and a3 start at 0. Stage 1 adds FRAC to a1; stage 2 adds the new a1 to a2; stage 3 adds the new a2 to a3.
  - Each sum of MOD or more subtracts MOD and gives carry c = 1.
  - y = c1 + c2 - c2' + c3 - 2·c3' + c3'', where ' marks the carry of the previous step and '' the carry of the step before that, both starting at 0.
- R5: With FRAC = 0, `div_value` stays equal to INT for every period.
- R6: After k modulator steps with sum of offsets S, the value MOD·S - k·FRAC lies within [-2·MOD, 2·MOD], so the average divide converges to INT + FRAC/MOD with no drift.
- R7: `psc_sel` = 0 selects the 4/5 prescaler (minimum realisable divide 12) and `psc_sel` = 1 selects the 8/9 prescaler (minimum 56). `div_err` rises one clock after `div_value` falls below the minimum for the selected prescaler.
- R8: With the 4/5 prescaler selected, `div_err` rises one clock after `div_value` exceeds 80. With the 8/9 prescaler selected, large values raise no error.
- R9: Once `div_err` is high it stays high until reset.
- R10: `div_pulse` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_val | input | INT_W (9) | Integer part of the ratio, 26..511 |
| frac_val | input | MOD_W (12) | Fractional numerator, below MOD |
| mod_val | input | MOD_W (12) | Fractional modulus, at least 1 |
| psc_sel | input | 1 | 0: 4/5 prescaler, 1: 8/9 prescaler |
| in_en | input | 1 | Input edge strobe, one count per high cycle |
| div_pulse | output | 1 | One-cycle strobe at the end of each divided period |
| div_value | output | DIV_W (10) | Divide value of the current period |
| div_err | output | 1 | Sticky flag for an unrealisable divide value |

## Verification
A corrupted accumulator or carry-delay register changes the offset sequence. That shows at the very next `div_pulse` as a `div_value` differing from the bench's reference modulator. Over many periods it also pushes the running drift outside its bound. A fault in the main, swallow or prescaler counters shows as a period length that disagrees with the announced `div_value` at the end of that same period. A faulty range check shows one clock after the offending value loads, or as a flag that drops.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

  localparam int unsigned PSC_LO_P  = 4;
  localparam int unsigned PSC_HI_P  = 8;
  localparam int unsigned LO_MAX_DIV = 80;
  localparam int unsigned OFS_W     = 4;

  typedef enum logic {
    PSC_4_5 = 1'b0,
    PSC_8_9 = 1'b1
  } psc_e;

  function automatic int unsigned base_mod(input psc_e s);
    return (s == PSC_8_9) ? PSC_HI_P : PSC_LO_P;
  endfunction

  // smallest divide where the swallow count never exceeds the main count
  function automatic int unsigned min_div(input psc_e s);
    return base_mod(s) * (base_mod(s) - 1);
  endfunction

endpackage

// File: rtl/fnd_acc_stage.sv
module fnd_acc_stage #(
  parameter int W = 12
) (
  input  logic [W-1:0] acc_q,
  input  logic [W-1:0] addend,
  input  logic [W-1:0] modulus,
  output logic [W-1:0] acc_d,
  output logic         carry
);

  logic [W:0] sum;
  logic [W:0] wrapped;

  assign sum     = {1'b0, acc_q} + {1'b0, addend};
  assign wrapped = sum - {1'b0, modulus};

  always_comb begin
    carry = (sum >= {1'b0, modulus});
    acc_d = carry ? wrapped[W-1:0] : sum[W-1:0];
  end

endmodule

// File: rtl/fnd_mash3.sv
module fnd_mash3 #(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic [W-1:0]        frac,
  input  logic [W-1:0]        modulus,
  output logic signed [3:0]   ofs
);

  localparam int NSTG = 3;

  logic [W-1:0] acc_q [NSTG];
  logic [W-1:0] acc_d [NSTG];
  logic [NSTG-1:0] cy;
  logic c2d, c3d, c3dd;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    logic [W-1:0] add;
    if (g == 0) begin : g_first
      assign add = frac;
    end else begin : g_chain
      assign add = acc_d[g-1];
    end
    fnd_acc_stage #(.W(W)) u_acc (
      .acc_q  (acc_q[g]),
      .addend (add),
      .modulus(modulus),
      .acc_d  (acc_d[g]),
      .carry  (cy[g])
    );
  end

  always_comb begin
    ofs = $signed({3'b000, cy[0]})
        + $signed({3'b000, cy[1]}) - $signed({3'b000, c2d})
        + $signed({3'b000, cy[2]}) - $signed({2'b00, c3d, 1'b0})
        + $signed({3'b000, c3dd});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTG; i++) acc_q[i] <= '0;
      c2d  <= 1'b0;
      c3d  <= 1'b0;
      c3dd <= 1'b0;
    end else if (step) begin
      for (int i = 0; i < NSTG; i++) acc_q[i] <= acc_d[i];
      c2d  <= cy[1];
      c3dd <= c3d;
      c3d  <= cy[2];
    end
  end

endmodule

// File: rtl/fnd_dm_counter.sv
module fnd_dm_counter
  import fnd_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_en,
  input  psc_e             psc,
  input  logic [DIV_W-1:0] load_val,
  output logic             term
);

  localparam int MW = DIV_W - 2;

  logic [MW-1:0] main_q;
  logic [2:0]    swal_q;
  logic [3:0]    pre_q;
  logic [3:0]    last_pre;
  logic          pre_wrap;
  logic [MW-1:0] load_main;
  logic [2:0]    load_swal;
  logic [DIV_W-1:0] sh_hi, sh_lo;

  assign sh_hi = load_val >> 3;
  assign sh_lo = load_val >> 2;

  always_comb begin
    if (psc == PSC_8_9) begin
      last_pre  = (swal_q != 3'd0) ? 4'd8 : 4'd7;
      load_main = sh_hi[MW-1:0];
      load_swal = load_val[2:0];
    end else begin
      last_pre  = (swal_q != 3'd0) ? 4'd4 : 4'd3;
      load_main = sh_lo[MW-1:0];
      load_swal = {1'b0, load_val[1:0]};
    end
    pre_wrap = in_en && (pre_q == last_pre);
    term     = pre_wrap && (main_q == MW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || term) begin
      main_q <= load_main;
      swal_q <= load_swal;
      pre_q  <= 4'd0;
    end else if (pre_wrap) begin
      pre_q  <= 4'd0;
      main_q <= main_q - MW'(1);
      if (swal_q != 3'd0) swal_q <= swal_q - 3'd1;
    end else if (in_en) begin
      pre_q <= pre_q + 4'd1;
    end
  end

endmodule

// File: rtl/fnd_range_chk.sv
module fnd_range_chk
  import fnd_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  psc_e             psc,
  input  logic [DIV_W-1:0] div_value,
  output logic             err
);

  logic too_low, too_high;

  always_comb begin
    too_low  = (32'(div_value) < min_div(psc));
    too_high = (psc == PSC_4_5) && (32'(div_value) > LO_MAX_DIV);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   err <= 1'b0;
    else if (too_low || too_high) err <= 1'b1;
  end

endmodule

// File: rtl/frac_n_divider.sv
module frac_n_divider
  import fnd_pkg::*;
#(
  parameter int INT_W = 9,
  parameter int MOD_W = 12,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] int_val,
  input  logic [MOD_W-1:0] frac_val,
  input  logic [MOD_W-1:0] mod_val,
  input  logic             psc_sel,
  input  logic             in_en,
  output logic             div_pulse,
  output logic [DIV_W-1:0] div_value,
  output logic             div_err
);

  localparam int SUM_W = DIV_W + 1;

  psc_e                    psc;
  logic signed [3:0]       mash_ofs;
  logic signed [SUM_W-1:0] d_sum;
  logic [DIV_W-1:0]        d_next;
  logic [DIV_W-1:0]        load_val;
  logic                    term;

  assign psc = psc_e'(psc_sel);

  fnd_mash3 #(.W(MOD_W)) u_mash (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (term),
    .frac   (frac_val),
    .modulus(mod_val),
    .ofs    (mash_ofs)
  );

  assign d_sum    = $signed({{(SUM_W-INT_W){1'b0}}, int_val}) + SUM_W'(mash_ofs);
  assign d_next   = d_sum[DIV_W-1:0];
  assign load_val = rst_n ? d_next : DIV_W'(int_val);

  fnd_dm_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_en   (in_en),
    .psc     (psc),
    .load_val(load_val),
    .term    (term)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_pulse <= 1'b0;
      div_value <= DIV_W'(int_val);
    end else begin
      div_pulse <= term;
      if (term) div_value <= d_next;
    end
  end

  fnd_range_chk #(.DIV_W(DIV_W)) u_rng (
    .clk      (clk),
    .rst_n    (rst_n),
    .psc      (psc),
    .div_value(div_value),
    .err      (div_err)
  );

  logic unused_sign;
  assign unused_sign = d_sum[SUM_W-1];

endmodule

// File: rtl/fnd_checker.sv
module fnd_checker #(
  parameter int INT_W = 9,
  parameter int MOD_W = 12,
  parameter int DIV_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_en,
  input logic [INT_W-1:0] int_val,
  input logic [MOD_W-1:0] frac_val,
  input logic             div_pulse,
  input logic [DIV_W-1:0] div_value,
  input logic             div_err,
  input logic signed [3:0] mash_ofs
);

  logic signed [DIV_W+1:0] val_s, int_s;
  assign val_s = $signed({2'b00, div_value});
  assign int_s = $signed({{(DIV_W+2-INT_W){1'b0}}, int_val});

  assert_ofs_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mash_ofs >= -4'sd3) && (mash_ofs <= 4'sd4));

  assert_value_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> (val_s == int_s + ($past(mash_ofs))));

  assert_frac_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_val == '0) |-> (mash_ofs == 4'sd0));

  assert_value_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_value) |-> div_pulse);

  assert_pulse_after_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> $past(in_en));

  assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |=> div_err);

endmodule

bind frac_n_divider fnd_checker #(.INT_W(INT_W), .MOD_W(MOD_W), .DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_en    (in_en),
  .int_val  (int_val),
  .frac_val (frac_val),
  .div_pulse(div_pulse),
  .div_value(div_value),
  .div_err  (div_err),
  .mash_ofs (mash_ofs)
);

// File: tb/tb_frac_n_divider.sv
`timescale 1ns/1ps
module tb_frac_n_divider;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  int_val = 9'd100;
  logic [11:0] frac_val = '0;
  logic [11:0] mod_val = 12'd1;
  logic        psc_sel = 1'b1;
  logic        in_en = 1'b0;
  logic        div_pulse;
  logic [9:0]  div_value;
  logic        div_err;

  always #2 clk = ~clk;

  frac_n_divider dut (
    .clk(clk), .rst_n(rst_n), .int_val(int_val), .frac_val(frac_val),
    .mod_val(mod_val), .psc_sel(psc_sel), .in_en(in_en),
    .div_pulse(div_pulse), .div_value(div_value), .div_err(div_err)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // reference modulator state
  longint m_a1, m_a2, m_a3;
  int m_c2d, m_c3d, m_c3dd;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit bad_div(input int d, input bit sel);
    if (sel) return d < 56;
    return (d < 12) || (d > 80);
  endfunction

  task automatic model_reset();
    m_a1 = 0; m_a2 = 0; m_a3 = 0;
    m_c2d = 0; m_c3d = 0; m_c3dd = 0;
  endtask

  task automatic model_step(input longint fv, input longint mv, output int y);
    int c1, c2, c3;
    longint s;
    s = m_a1 + fv; c1 = (s >= mv) ? 1 : 0; m_a1 = c1 ? s - mv : s;
    s = m_a2 + m_a1; c2 = (s >= mv) ? 1 : 0; m_a2 = c2 ? s - mv : s;
    s = m_a3 + m_a2; c3 = (s >= mv) ? 1 : 0; m_a3 = c3 ? s - mv : s;
    y = c1 + c2 - m_c2d + c3 - 2 * m_c3d + m_c3dd;
    m_c2d = c2; m_c3dd = m_c3d; m_c3d = c3;
  endtask

  task automatic run(input int iv, input int fv, input int mv, input bit sel,
                     input int periods, input int dens);
    int cnt, d_cur, y, npul;
    bit prev_en, en, err_exp, prev_pulse;
    longint ssum, k, e;
    in_en = 1'b0;
    rst_n = 1'b0;
    int_val = 9'(iv); frac_val = 12'(fv); mod_val = 12'(mv); psc_sel = sel;
    repeat (3) @(negedge clk);
    chk(div_value == 10'(iv), "R1 div_value", div_value, iv);
    chk(div_pulse == 1'b0, "R1 div_pulse", div_pulse, 0);
    chk(div_err == 1'b0, "R1 div_err", div_err, 0);
    rst_n = 1'b1;
    model_reset();
    d_cur = iv; err_exp = bad_div(iv, sel);
    cnt = 0; npul = 0; prev_en = 0; prev_pulse = 0; ssum = 0; k = 0;
    while (npul < periods && !done) begin
      @(negedge clk);
      cnt += int'(prev_en);
      if (prev_pulse) chk(div_pulse == 1'b0, "R10 pulse width", div_pulse, 0);
      prev_pulse = div_pulse;
      if (div_pulse) begin
        if (!err_exp) chk(cnt == d_cur, "R2 period length", cnt, d_cur);
        chk(div_err == err_exp, sel ? "R7 err flag" : "R8 err flag", div_err, err_exp);
        model_step(fv, mv, y);
        d_cur = iv + y;
        chk(int'(div_value) == d_cur, "R4 divide value", div_value, d_cur);
        chk(y >= -3 && y <= 4, "R3 offset range", y, 0);
        if (fv == 0) chk(int'(div_value) == iv, "R5 frac zero", div_value, iv);
        ssum += y; k++;
        e = longint'(mv) * ssum - k * longint'(fv);
        chk(e >= -2 * longint'(mv) && e <= 2 * longint'(mv), "R6 drift", e, 0);
        if (bad_div(d_cur, sel)) err_exp = 1'b1;
        cnt = 0; npul++;
      end
      en = ($urandom % 100) < dens;
      in_en = en; prev_en = en;
    end
    in_en = 1'b0;
    repeat (30) @(negedge clk);
    chk(div_err == err_exp, err_exp ? "R9 err sticky" : "R7 no err", div_err, err_exp);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    run(100, 0, 7, 1'b1, 20, 100);       // R5 fractional zero
    run(26, 1, 3, 1'b0, 30, 70);         // minimum INT, 4/5
    run(76, 2999, 3000, 1'b0, 30, 100);  // R8 upper edge, no error
    run(511, 4094, 4095, 1'b1, 20, 100); // maximum INT
    run(40, 5, 9, 1'b1, 20, 100);        // R7 below 8/9 minimum
    run(90, 0, 1, 1'b0, 10, 100);        // R8 above 80 with 4/5
    run(59, 1, 2, 1'b1, 40, 80);         // R7 near 8/9 minimum
    for (int i = 0; i < 3; i++) begin
      int iv, mv, fv, dn;
      iv = 60 + int'($urandom % 200);
      mv = 2 + int'($urandom % 4000);
      fv = int'($urandom % mv);
      dn = 50 + int'($urandom % 51);
      run(iv, fv, mv, 1'b1, 40, dn);
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      vectors++; fails++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule